// File: doc/BRIEF.md
# Prescaled Seconds Counter

A seconds-keeping peripheral on a 16-bit register bus. A strobe from the slow timekeeping clock drives a reloadable down-counting prescaler. Each time the prescaler passes through zero it issues a tick. The tick advances a 32-bit seconds count. A 32-bit alarm value is compared against the count on every tick. Second, alarm and wrap events latch into sticky flags, and each flag has its own interrupt enable.

Software changes the reload, count and alarm only inside a configuration window. Setting the configuration bit takes a private copy of the live values. Bus writes edit that copy. Clearing the bit starts a commit that lasts a fixed number of slow-clock strobes, and the staged values reach the live registers when the commit ends. A write-done bit shows whether a commit is still running. A separate synchronised bit tells software when the readable copies of the timekeeping state can be trusted after reset.

The whole block runs on the bus clock. The slow clock arrives as a single-cycle enable strobe `slow_en`, so there is no clock-domain crossing inside the block.

Top module: `secs_rtc`

## Requirements
- R1: After reset the block reads as follows:
  - control word (byte offset 0x04) = 0x0020;
  - enable word (0x00) = 0;
  - count = 0 and alarm = 0;
  - reload = RELOAD_RST (32767);
  - down-count = RELOAD_RST;
  - `irq` = 0.
- R2: The prescaler counts down once per `slow_en` strobe, from the reload value R to 0. On the strobe where it is at 0 it returns to R and emits a tick, so it divides by R+1. The down-count reads at offsets 0x10 (upper bits) and 0x14 (low 16 bits). Writes to those offsets have no effect.
- R3: Each tick adds one to the seconds count, and the count wraps from 0xFFFFFFFF to 0. That wrap sets the overflow flag, bit 2 of the control word.
- R4: While the configuration bit (bit 4 of the control word) is 0, writes to the following offsets are ignored:
  - reload: 0x08 for the upper bits, 0x0C for the low half;
  - count: 0x18 for the high half, 0x1C for the low half;
  - alarm: 0x20 for the high half, 0x24 for the low half.
- R5: Values written during configuration become live only at the end of a commit. The commit starts when bit 4 is written from 1 to 0 and completes on the third `slow_en` strobe after that write. Write-done (bit 5) reads 0 from that write until the commit completes, and reads 1 otherwise. A committed reload also restarts the down-count at the new reload value.
- R6: Writing 1 to bit 4 while a commit is running is ignored, and bit 4 stays 0.
- R7: The alarm flag (bit 1) sets on the tick whose new count equals the alarm value.
- R8: The second flag (bit 0) sets on every tick.
- R9: Writing the control word clears each of bits 0 to 2 where the written bit is 0 and leaves it unchanged where the written bit is 1. If a flag is set and cleared in the same cycle, the set wins.
- R10: `irq` is high exactly when some flag is set and its enable is set. The enables are in the enable word at offset 0x00: bit 0 for second, bit 1 for alarm, bit 2 for overflow.
- R11: The synchronised bit (bit 3 of the control word) is 0 after reset. It sets on the second `slow_en` strobe after reset and then stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_en | input | 1 | One-cycle strobe per slow timekeeping clock period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register (word aligned) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, OR of enabled flags |

## Verification
A wrong down-count or reload shows up right away on the down-count registers, which are compared after every strobe. The tick position is visible within R+1 strobes as a seconds count that advances one strobe early or late. A fault in the staging copy or the pending marks stays hidden until a commit ends. It then shows three strobes after configuration is left, as a count, reload or alarm that differs from the value written. The sweep reads every live register one strobe before that point and again at that point. Flag and enable faults appear at `irq` and in the control word on the very tick that should set them.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;
  localparam int HALF_W = 16;
  localparam int CNT_W  = 32;
  // word index decoded from bus_addr[5:2]
  localparam logic [3:0] RG_IEN = 4'd0;
  localparam logic [3:0] RG_CTL = 4'd1;
  localparam logic [3:0] RG_RLH = 4'd2;
  localparam logic [3:0] RG_RLL = 4'd3;
  localparam logic [3:0] RG_DVH = 4'd4;
  localparam logic [3:0] RG_DVL = 4'd5;
  localparam logic [3:0] RG_CNH = 4'd6;
  localparam logic [3:0] RG_CNL = 4'd7;
  localparam logic [3:0] RG_ALH = 4'd8;
  localparam logic [3:0] RG_ALL = 4'd9;
  // control word bit positions
  localparam int B_SEC   = 0;
  localparam int B_ALM   = 1;
  localparam int B_OVF   = 2;
  localparam int B_SYNC  = 3;
  localparam int B_CFG   = 4;
  localparam int B_WDONE = 5;
  localparam int N_EVT   = 3;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W = 20,
  parameter int RELOAD_RST = 32767
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_en,
  input  logic             load,
  input  logic [PRE_W-1:0] load_val,
  input  logic [PRE_W-1:0] reload,
  output logic [PRE_W-1:0] div_o,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q, div_n;
  logic             div_en;

  assign tick_o = slow_en && (div_q == '0);

  always_comb begin
    div_n = div_q;
    if (load)        div_n = load_val;
    else if (tick_o) div_n = reload;
    else             div_n = div_q - 1'b1;
  end

  assign div_en = load || slow_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= PRE_W'(RELOAD_RST);
    else if (div_en) div_q <= div_n;
  end

  assign div_o = div_q;
endmodule

// File: rtl/rtc_commit.sv
module rtc_commit #(
  parameter int COMMIT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_en,
  input  logic start,
  output logic busy_o,
  output logic fire_o
);
  localparam int CW = $clog2(COMMIT_LEN + 1);
  logic [CW-1:0] left_q, left_n;

  assign busy_o = (left_q != '0);
  assign fire_o = busy_o && slow_en && (left_q == CW'(1));

  always_comb begin
    left_n = left_q;
    if (start)                 left_n = CW'(COMMIT_LEN);
    else if (busy_o && slow_en) left_n = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_n;
  end
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] keep_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flg_q, flg_n;

  always_comb begin
    flg_n = flg_q;
    if (wr_i) flg_n = flg_q & keep_i;
    flg_n = flg_n | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_n;
  end

  assign flags_o = flg_q;
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
  import secs_rtc_pkg::*;
#(
  parameter int PRE_W      = 20,
  parameter int RELOAD_RST = 32767,
  parameter int COMMIT_LEN = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_en,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);
  logic [3:0]       widx;
  logic [N_EVT-1:0] en_q, en_n;
  logic             cfg_q, cfg_n;
  logic             seen_q, sync_q;
  logic [PRE_W-1:0] reload_q, reload_n, div;
  logic [CNT_W-1:0] cnt_q, cnt_n, alr_q, alr_n;
  logic [CNT_W-1:0] stg_prl_q, stg_prl_n, stg_cnt_q, stg_cnt_n, stg_alr_q, stg_alr_n;
  logic [2:0]       pend_q, pend_n;
  logic             tick, busy, fire, commit_start, flag_wr;
  logic [N_EVT-1:0] evt, flags;
  logic [31:0]      rl32, dv32;

  assign widx = bus_addr[5:2];
  assign rl32 = 32'(reload_q);
  assign dv32 = 32'(div);

  rtc_prescaler #(.PRE_W(PRE_W), .RELOAD_RST(RELOAD_RST)) u_pre (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en),
    .load(fire && pend_q[0]), .load_val(stg_prl_q[PRE_W-1:0]),
    .reload(reload_q), .div_o(div), .tick_o(tick));

  rtc_commit #(.COMMIT_LEN(COMMIT_LEN)) u_cmt (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en),
    .start(commit_start), .busy_o(busy), .fire_o(fire));

  assign evt[B_SEC] = tick;
  assign evt[B_ALM] = tick && ((cnt_q + 1'b1) == alr_q);
  assign evt[B_OVF] = tick && (cnt_q == '1);

  rtc_flags #(.N(N_EVT)) u_flg (
    .clk(clk), .rst_n(rst_n), .set_i(evt), .wr_i(flag_wr),
    .keep_i(bus_wdata[N_EVT-1:0]), .flags_o(flags));

  // bus write decode and staging
  always_comb begin
    en_n = en_q; cfg_n = cfg_q; pend_n = pend_q;
    stg_prl_n = stg_prl_q; stg_cnt_n = stg_cnt_q; stg_alr_n = stg_alr_q;
    commit_start = 1'b0; flag_wr = 1'b0;
    if (bus_wr) begin
      case (widx)
        RG_IEN: en_n = bus_wdata[N_EVT-1:0];
        RG_CTL: begin
          flag_wr = 1'b1;
          if (bus_wdata[B_CFG] && !cfg_q && !busy) begin
            cfg_n = 1'b1; pend_n = '0;
            stg_prl_n = rl32; stg_cnt_n = cnt_q; stg_alr_n = alr_q;
          end else if (!bus_wdata[B_CFG] && cfg_q) begin
            cfg_n = 1'b0; commit_start = 1'b1;
          end
        end
        RG_RLH: if (cfg_q) begin stg_prl_n[31:16] = bus_wdata; pend_n[0] = 1'b1; end
        RG_RLL: if (cfg_q) begin stg_prl_n[15:0]  = bus_wdata; pend_n[0] = 1'b1; end
        RG_CNH: if (cfg_q) begin stg_cnt_n[31:16] = bus_wdata; pend_n[1] = 1'b1; end
        RG_CNL: if (cfg_q) begin stg_cnt_n[15:0]  = bus_wdata; pend_n[1] = 1'b1; end
        RG_ALH: if (cfg_q) begin stg_alr_n[31:16] = bus_wdata; pend_n[2] = 1'b1; end
        RG_ALL: if (cfg_q) begin stg_alr_n[15:0]  = bus_wdata; pend_n[2] = 1'b1; end
        default: ;
      endcase
    end
  end

  // live timekeeping registers
  always_comb begin
    reload_n = (fire && pend_q[0]) ? stg_prl_q[PRE_W-1:0] : reload_q;
    alr_n    = (fire && pend_q[2]) ? stg_alr_q : alr_q;
    if (fire && pend_q[1]) cnt_n = stg_cnt_q;
    else if (tick)         cnt_n = cnt_q + 1'b1;
    else                   cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; cfg_q <= 1'b0; pend_q <= '0;
      stg_prl_q <= '0; stg_cnt_q <= '0; stg_alr_q <= '0;
      reload_q <= PRE_W'(RELOAD_RST); cnt_q <= '0; alr_q <= '0;
      seen_q <= 1'b0; sync_q <= 1'b0;
    end else begin
      en_q <= en_n; cfg_q <= cfg_n; pend_q <= pend_n;
      stg_prl_q <= stg_prl_n; stg_cnt_q <= stg_cnt_n; stg_alr_q <= stg_alr_n;
      if (fire) begin
        reload_q <= reload_n;
        alr_q    <= alr_n;
      end
      if (fire || tick) cnt_q <= cnt_n;
      if (slow_en) begin
        seen_q <= 1'b1;
        sync_q <= sync_q | seen_q;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (widx)
      RG_IEN: bus_rdata = 16'(en_q);
      RG_CTL: begin
        bus_rdata[N_EVT-1:0] = flags;
        bus_rdata[B_SYNC]    = sync_q;
        bus_rdata[B_CFG]     = cfg_q;
        bus_rdata[B_WDONE]   = !busy;
      end
      RG_RLH: bus_rdata = rl32[31:16];
      RG_RLL: bus_rdata = rl32[15:0];
      RG_DVH: bus_rdata = dv32[31:16];
      RG_DVL: bus_rdata = dv32[15:0];
      RG_CNH: bus_rdata = cnt_q[31:16];
      RG_CNL: bus_rdata = cnt_q[15:0];
      RG_ALH: bus_rdata = alr_q[31:16];
      RG_ALL: bus_rdata = alr_q[15:0];
      default: ;
    endcase
  end

  assign irq = |(flags & en_q);
endmodule

// File: rtl/secs_rtc_chk.sv
module secs_rtc_chk #(
  parameter int PRE_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             fire,
  input logic [2:0]       pend_q,
  input logic [31:0]      cnt_q,
  input logic             sync_q,
  input logic [PRE_W-1:0] reload_q,
  input logic [PRE_W-1:0] div,
  input logic             irq,
  input logic [2:0]       flags,
  input logic             busy
);
  // R3: the count moves only on a tick or a commit
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !fire) |=> $stable(cnt_q));

  // R3: a tick without a count commit adds exactly one
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(fire && pend_q[1])) |=> (cnt_q == $past(cnt_q) + 32'd1));

  // R4, R5: the live reload changes only when a commit completes
  p_reload_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(reload_q));

  // R2: the down-count never exceeds the live reload
  p_div_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div <= reload_q);

  // R11: once set, the synchronised bit stays set
  p_sync_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |=> sync_q);

  // R10: an interrupt needs at least one latched flag
  p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 3'b000));

  // R5: a commit completes only while one is running
  p_fire_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> busy);
endmodule

bind secs_rtc secs_rtc_chk #(.PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .fire(fire), .pend_q(pend_q),
  .cnt_q(cnt_q), .sync_q(sync_q), .reload_q(reload_q), .div(div),
  .irq(irq), .flags(flags), .busy(busy));

// File: tb/secs_rtc_bench.sv
module secs_rtc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  localparam logic [5:0] A_IEN = 6'h00, A_CTL = 6'h04, A_RLH = 6'h08, A_RLL = 6'h0C,
                         A_DVH = 6'h10, A_DVL = 6'h14, A_CNH = 6'h18, A_CNL = 6'h1C,
                         A_ALH = 6'h20, A_ALL = 6'h24;

  secs_rtc u_secs_rtc (.clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic rd32(input logic [5:0] hi, input logic [5:0] lo, output logic [31:0] d);
    logic [15:0] h, l;
    rd(hi, h); rd(lo, l); d = {h, l};
  endtask

  task automatic pulse();
    @(negedge clk); slow_en = 1'b1;
    @(negedge clk); slow_en = 1'b0;
  endtask

  task automatic stage(input logic [31:0] r, input logic [31:0] c, input logic [31:0] al);
    wr(A_CTL, 16'h0010);
    wr(A_RLH, r[31:16]); wr(A_RLL, r[15:0]);
    wr(A_CNH, c[31:16]); wr(A_CNL, c[15:0]);
    wr(A_ALH, al[31:16]); wr(A_ALL, al[15:0]);
    wr(A_CTL, 16'h0000);
  endtask

  task automatic load_all(input logic [31:0] r, input logic [31:0] c, input logic [31:0] al);
    stage(r, c, al);
    repeat (3) pulse();
    wr(A_CTL, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_IEN, v); check("R1 enable word", 32'(v), 0);
    rd(A_CTL, v); check("R1 control word", 32'(v), 32'h20);
    rd32(A_CNH, A_CNL, w); check("R1 count", w, 0);
    rd32(A_ALH, A_ALL, w); check("R1 alarm", w, 0);
    rd32(A_RLH, A_RLL, w); check("R1 reload", w, 32767);
    rd32(A_DVH, A_DVL, w); check("R1 down-count", w, 32767);
    check("R1 irq", 32'(irq), 0);

    // R11 sync bit
    pulse(); rd(A_CTL, v); check("R11 sync after one strobe", 32'(v[3]), 0);
    pulse(); rd(A_CTL, v); check("R11 sync after two strobes", 32'(v[3]), 1);
    pulse(); rd(A_CTL, v); check("R11 sync stays", 32'(v[3]), 1);

    // R5, R6 commit timing
    stage(32'd3, 32'h0001_2345, 32'h100);
    rd(A_CTL, v); check("R5 write-done low at commit start", 32'(v[5]), 0);
    pulse();
    wr(A_CTL, 16'h0010);
    rd(A_CTL, v); check("R6 config bit ignored during commit", 32'(v[4]), 0);
    pulse();
    rd32(A_CNH, A_CNL, w); check("R5 count not live before end", w, 0);
    rd(A_CTL, v); check("R5 write-done low mid commit", 32'(v[5]), 0);
    pulse();
    rd32(A_CNH, A_CNL, w); check("R5 count live at end", w, 32'h0001_2345);
    rd32(A_RLH, A_RLL, w); check("R5 reload live", w, 3);
    rd32(A_ALH, A_ALL, w); check("R5 alarm live", w, 32'h100);
    rd32(A_DVH, A_DVL, w); check("R5 down-count restarted", w, 3);
    rd(A_CTL, v); check("R5 write-done back high", 32'(v[5]), 1);

    // R4 writes outside configuration ignored; R2 down-count read-only
    wr(A_CNL, 16'hFFFF); wr(A_RLL, 16'h0000); wr(A_ALL, 16'h0055); wr(A_DVL, 16'h0000);
    rd32(A_CNH, A_CNL, w); check("R4 count unchanged", w, 32'h0001_2345);
    rd32(A_RLH, A_RLL, w); check("R4 reload unchanged", w, 3);
    rd32(A_ALH, A_ALL, w); check("R4 alarm unchanged", w, 32'h100);
    rd32(A_DVH, A_DVL, w); check("R2 down-count write ignored", w, 3);

    // R2, R3, R8 sweep over small reload values
    for (int r = 0; r < 5; r++) begin
      logic [31:0] c0;
      c0 = 32'(1000 * r + 7);
      load_all(32'(r), c0, 32'h0);
      rd32(A_DVH, A_DVL, w); check("R2 down-count after load", w, 32'(r));
      for (int k = 1; k <= 3 * (r + 1) + 1; k++) begin
        pulse();
        rd32(A_CNH, A_CNL, w); check("R3 count per tick", w, c0 + 32'(k / (r + 1)));
        rd32(A_DVH, A_DVL, w); check("R2 down-count", w, 32'(r - (k % (r + 1))));
      end
      rd(A_CTL, v); check("R8 second flag set", 32'(v[0]), 1);
    end

    // R7 alarm
    load_all(32'd0, 32'd5, 32'd8);
    pulse(); pulse();
    rd(A_CTL, v); check("R7 alarm flag before match", 32'(v[1]), 0);
    pulse();
    rd32(A_CNH, A_CNL, w); check("R7 count at match", w, 8);
    rd(A_CTL, v); check("R7 alarm flag at match", 32'(v[1]), 1);

    // R9 flag write semantics
    wr(A_CTL, 16'h0007);
    rd(A_CTL, v); check("R9 writing ones keeps flags", 32'(v[2:0]), 3);
    wr(A_CTL, 16'h0006);
    rd(A_CTL, v); check("R9 writing zero clears second flag", 32'(v[2:0]), 2);

    // R10 interrupt enables
    wr(A_IEN, 16'h0001); rd(A_IEN, v); check("R10 irq second-only enable", 32'(irq), 0);
    wr(A_IEN, 16'h0002); rd(A_IEN, v); check("R10 irq alarm enable", 32'(irq), 1);
    wr(A_IEN, 16'h0000); rd(A_IEN, v); check("R10 irq disabled", 32'(irq), 0);

    // R3 wrap and overflow flag
    load_all(32'd0, 32'hFFFF_FFFE, 32'h0);
    pulse();
    rd32(A_CNH, A_CNL, w); check("R3 count at all ones", w, 32'hFFFF_FFFF);
    rd(A_CTL, v); check("R3 overflow flag before wrap", 32'(v[2]), 0);
    pulse();
    rd32(A_CNH, A_CNL, w); check("R3 count wraps", w, 0);
    rd(A_CTL, v); check("R3 overflow flag on wrap", 32'(v[2]), 1);
    wr(A_IEN, 16'h0004); rd(A_IEN, v); check("R10 irq overflow enable", 32'(irq), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule